// File: doc/BRIEF.md
# Watermark-Gated Receive FIFO Egress

This block is the receive-side buffer of a cell/packet interface. An upstream source pushes words tagged with start-of-packet and end-of-packet bits into a FIFO. A bus master drains the FIFO through an egress port that offers an available flag, a read enable, data, start/end markers and a valid qualifier.

The available flag is raised when the stored amount reaches a programmable low mark, or when a complete cell/packet is stored, which is known from a count of resident end markers. A read that has begun keeps going until its end marker leaves or the FIFO runs dry, even when the level is below the mark. An enabled read that is not allowed returns a filler word and removes nothing.

Two framing modes exist. In cell mode the flag follows the mark and end-marker condition only. In packet mode the flag is also held high while a started transfer still has stored data. A static setting picks a one-clock or two-clock response for both data and flag.

Top module: `rxf_egress`

## Requirements
- R1: rx_avail, seen after a clock edge, is 1 when before that edge the stored word count was at least the captured low mark or at least one stored word carried the EOP bit (one-clock flag latency).
- R2: In cell mode (cfg_pkt_mode=0), rx_avail is 0 when the count is below the mark and no EOP word is stored, including right after the last word of a cell has been read.
- R3: With cfg_two_cycle=0, a word removed at an edge where rd_enb is sampled high appears on rx_data/rx_sop/rx_eop with rx_valid=1 right after that same edge.
- R4: With cfg_two_cycle=1, both the data path (rx_valid, rx_data, rx_sop, rx_eop) and rx_avail appear one clock later than with cfg_two_cycle=0.
- R5: rd_enb high when the R1 condition is false and no transfer is in progress gives rx_valid=0, rx_data all-zero, rx_sop=0, rx_eop=0, and removes no word; the next real read returns the oldest word.
- R6: Once a word without the EOP bit has been read, each further enabled read removes a word regardless of the mark, until a word with EOP is read or the FIFO is empty; an enabled read on an empty FIFO gives filler (rx_valid=0) and nothing else.
- R7: In packet mode (cfg_pkt_mode=1), while a transfer is in progress and the FIFO holds data, rx_avail stays 1 even below the mark with no EOP stored; it falls one edge after the FIFO is drained.
- R8: The count of stored EOP words goes up on an EOP write and down on an EOP read; a write and a read of EOP words in the same cycle leave it unchanged.
- R9: The low mark is taken from cfg_low_mark during reset and at edges where the FIFO is empty with no transfer in progress; changes at any other time have no effect on rx_avail.
- R10: wr_full is 1 exactly when DEPTH words are stored; a write while full is discarded.
- R11: During and right after reset, rx_avail, rx_valid, rx_sop, rx_eop and wr_full are 0 and rx_data is all-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pkt_mode | input | 1 | Framing: 0 = cell mode, 1 = packet mode |
| cfg_two_cycle | input | 1 | Response latency: 0 = one clock, 1 = two clocks |
| cfg_low_mark | input | CNT_W | Low mark in words, captured while idle |
| wr_en | input | 1 | Push a word this cycle |
| wr_data | input | DATA_W | Word to push |
| wr_sop | input | 1 | Pushed word starts a cell/packet |
| wr_eop | input | 1 | Pushed word ends a cell/packet |
| wr_full | output | 1 | FIFO holds DEPTH words |
| rd_enb | input | 1 | Master read enable |
| rx_avail | output | 1 | Data available flag |
| rx_valid | output | 1 | rx_data came from the FIFO (0 = filler) |
| rx_data | output | DATA_W | Egress word |
| rx_sop | output | 1 | Egress word starts a cell/packet |
| rx_eop | output | 1 | Egress word ends a cell/packet |

## Verification
Every result is due at a fixed edge: with the one-clock setting, the flag and the word chosen by the enable sampled at edge N show right after edge N, and with the two-clock setting right after edge N+1. The bench keeps a queue model with its own level, end-marker count, transfer bit and captured mark, computes before each edge what that edge decides, pushes the results into two expected stages, and compares the port values at the following falling edge against the stage the latency setting selects. Directed sequences then drive reset, filler reads, mark changes during a transfer, packet-mode hold, simultaneous end-marker traffic and a full FIFO, each with explicit checks at the cycle worked out from those latencies.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef enum logic {
    FRAME_CELL = 1'b0,
    FRAME_PKT  = 1'b1
  } frame_e;

  // Flag term from level and resident end markers.
  function automatic logic avail_calc(input int unsigned level,
                                      input int unsigned mark,
                                      input int unsigned eops);
    return (level >= mark) || (eops != 0);
  endfunction

  // Extra hold term used only by packet framing.
  function automatic logic hold_calc(input frame_e mode,
                                     input logic   in_xfer,
                                     input logic   non_empty);
    return (mode == FRAME_PKT) && in_xfer && non_empty;
  endfunction

  // Pointer step that also works for a depth that is not a power of two.
  function automatic int unsigned ptr_next(input int unsigned p,
                                           input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_sop,
  input  logic              wr_eop,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic              head_sop,
  output logic              head_eop,
  output logic [CNT_W-1:0]  level,
  output logic [CNT_W-1:0]  eop_cnt,
  output logic              full,
  output logic              empty
);
  import rxf_pkg::*;

  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int WORD_W = DATA_W + 2;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  level_q, eops_q;
  logic [WORD_W-1:0] head_word;
  logic              eop_in, eop_out;

  assign head_word = mem[rd_ptr];
  assign head_data = head_word[DATA_W-1:0];
  assign head_eop  = head_word[DATA_W];
  assign head_sop  = head_word[DATA_W+1];

  assign eop_in  = push && wr_eop;
  assign eop_out = pop && head_eop;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= {wr_sop, wr_eop, wr_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level_q <= '0;
      eops_q  <= '0;
    end else begin
      if (push) wr_ptr <= ADDR_W'(ptr_next(32'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= ADDR_W'(ptr_next(32'(rd_ptr), DEPTH));
      case ({push, pop})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
      case ({eop_in, eop_out})
        2'b10:   eops_q <= eops_q + 1'b1;
        2'b01:   eops_q <= eops_q - 1'b1;
        default: eops_q <= eops_q;
      endcase
    end
  end

  assign level   = level_q;
  assign eop_cnt = eops_q;
  assign full    = (level_q == CNT_W'(DEPTH));
  assign empty   = (level_q == '0);

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= CNT_W'(DEPTH));

  // R8
  eop_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eops_q <= level_q);

  // R6
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/rxf_gate.sv
module rxf_gate #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_pkt_mode,
  input  logic [CNT_W-1:0] cfg_low_mark,
  input  logic             rd_enb,
  input  logic [CNT_W-1:0] level,
  input  logic [CNT_W-1:0] eop_cnt,
  input  logic             empty,
  input  logic             head_eop,
  output logic             pop,
  output logic             flag_raw
);
  import rxf_pkg::*;

  logic [CNT_W-1:0] mark_q;
  logic             in_xfer;
  logic             avail_now;
  logic             idle;
  frame_e           mode;

  assign mode      = frame_e'(cfg_pkt_mode);
  assign avail_now = avail_calc(32'(level), 32'(mark_q), 32'(eop_cnt));
  assign idle      = empty && !in_xfer;
  assign pop       = rd_enb && !empty && (avail_now || in_xfer);
  assign flag_raw  = avail_now || hold_calc(mode, in_xfer, !empty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mark_q  <= cfg_low_mark;
      in_xfer <= 1'b0;
    end else begin
      if (idle) mark_q <= cfg_low_mark;
      if (pop)        in_xfer <= !head_eop;
      else if (empty) in_xfer <= 1'b0;
    end
  end

  // R9
  mark_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(mark_q));

  // R6
  xfer_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && head_eop) |=> !in_xfer);

endmodule

// File: rtl/rxf_outpipe.sv
module rxf_outpipe #(
  parameter int DATA_W = 8,
  parameter int NSTAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_late,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_flag,
  output logic              out_valid,
  output logic              out_sop,
  output logic              out_eop,
  output logic [DATA_W-1:0] out_data,
  output logic              out_flag
);
  localparam int PW   = DATA_W + 3;
  localparam int LAST = NSTAGE - 1;

  logic [PW-1:0] pw_q [NSTAGE];
  logic          fl_q [NSTAGE];
  logic [PW-1:0] pick;

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pw_q[0] <= '0;
          fl_q[0] <= 1'b0;
        end else begin
          pw_q[0] <= {in_valid, in_sop, in_eop, in_data};
          fl_q[0] <= in_flag;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pw_q[g] <= '0;
          fl_q[g] <= 1'b0;
        end else begin
          pw_q[g] <= pw_q[g-1];
          fl_q[g] <= fl_q[g-1];
        end
      end
    end
  end

  assign pick      = sel_late ? pw_q[LAST] : pw_q[0];
  assign out_flag  = sel_late ? fl_q[LAST] : fl_q[0];
  assign out_valid = pick[PW-1];
  assign out_sop   = pick[PW-2];
  assign out_eop   = pick[PW-3];
  assign out_data  = pick[DATA_W-1:0];

endmodule

// File: rtl/rxf_egress.sv
module rxf_egress #(
  parameter int                DATA_W = 8,
  parameter int                DEPTH  = 16,
  parameter int                CNT_W  = $clog2(DEPTH + 1),
  parameter logic [DATA_W-1:0] FILL   = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_pkt_mode,
  input  logic              cfg_two_cycle,
  input  logic [CNT_W-1:0]  cfg_low_mark,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_sop,
  input  logic              wr_eop,
  output logic              wr_full,
  input  logic              rd_enb,
  output logic              rx_avail,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_sop,
  output logic              rx_eop
);
  localparam int NSTAGE = 2;

  logic              push, pop, full, empty;
  logic              head_sop, head_eop, flag_raw;
  logic [DATA_W-1:0] head_data, sel_data;
  logic [CNT_W-1:0]  level, eop_cnt;

  assign push     = wr_en && !full;
  assign wr_full  = full;
  assign sel_data = pop ? head_data : FILL;

  rxf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .wr_data(wr_data),
    .wr_sop(wr_sop), .wr_eop(wr_eop), .pop(pop), .head_data(head_data),
    .head_sop(head_sop), .head_eop(head_eop), .level(level),
    .eop_cnt(eop_cnt), .full(full), .empty(empty)
  );

  rxf_gate #(.CNT_W(CNT_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .cfg_pkt_mode(cfg_pkt_mode),
    .cfg_low_mark(cfg_low_mark), .rd_enb(rd_enb), .level(level),
    .eop_cnt(eop_cnt), .empty(empty), .head_eop(head_eop),
    .pop(pop), .flag_raw(flag_raw)
  );

  rxf_outpipe #(.DATA_W(DATA_W), .NSTAGE(NSTAGE)) u_pipe (
    .clk(clk), .rst_n(rst_n), .sel_late(cfg_two_cycle),
    .in_valid(pop), .in_sop(pop && head_sop), .in_eop(pop && head_eop),
    .in_data(sel_data), .in_flag(flag_raw),
    .out_valid(rx_valid), .out_sop(rx_sop), .out_eop(rx_eop),
    .out_data(rx_data), .out_flag(rx_avail)
  );

  // R3
  one_cycle_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_two_cycle && rx_valid) |-> $past(rd_enb));

  // R10
  full_blocks_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_full && !pop) |=> wr_full);

endmodule

// File: tb/sim_rxf_egress.sv
module sim_rxf_egress;
  localparam int CLK_PERIOD = 10;
  localparam int DW         = 8;
  localparam int DEPTH      = 16;
  localparam int CW         = $clog2(DEPTH + 1);
  localparam int NV         = 22;
  // {wr, sop, eop, rd, data[7:0]}
  localparam logic [11:0] VEC [NV] = '{
    12'hC10, 12'h811, 12'h812, 12'hA13, 12'h100, 12'h100, 12'h100, 12'h100,
    12'h100, 12'hC20, 12'h100, 12'h821, 12'h822, 12'hB23, 12'h100, 12'hD30,
    12'h100, 12'hB31, 12'h100, 12'h100, 12'h100, 12'h000
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_pkt_mode = 1'b0, cfg_two_cycle = 1'b0;
  logic [CW-1:0] cfg_low_mark = CW'(4);
  logic          wr_en = 1'b0, wr_sop = 1'b0, wr_eop = 1'b0, rd_enb = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_full, rx_avail, rx_valid, rx_sop, rx_eop;
  logic [DW-1:0] rx_data;

  int n_chk = 0;
  int n_err = 0;

  // reference model
  logic [9:0]  mq[$];
  int          m_mark, m_eops;
  bit          m_xfer;
  logic        e_av1, e_av2;
  logic [10:0] e_w1, e_w2;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxf_egress #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_pkt_mode(cfg_pkt_mode),
    .cfg_two_cycle(cfg_two_cycle), .cfg_low_mark(cfg_low_mark),
    .wr_en(wr_en), .wr_data(wr_data), .wr_sop(wr_sop), .wr_eop(wr_eop),
    .wr_full(wr_full), .rd_enb(rd_enb), .rx_avail(rx_avail),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_sop(rx_sop), .rx_eop(rx_eop)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic pkt, input logic two, input int mark);
    rst_n = 1'b0;
    cfg_pkt_mode = pkt; cfg_two_cycle = two; cfg_low_mark = CW'(mark);
    wr_en = 0; wr_sop = 0; wr_eop = 0; wr_data = '0; rd_enb = 0;
    repeat (2) @(negedge clk);
    mq.delete(); m_eops = 0; m_xfer = 0; m_mark = mark;
    e_av1 = 0; e_av2 = 0; e_w1 = '0; e_w2 = '0;
    rst_n = 1'b1;
  endtask

  task automatic step(input logic wr, input logic sop, input logic eop,
                      input logic [7:0] d, input logic rd, input string tag);
    int lev; logic avc, fr, pp, ps; logic [9:0] hd; logic [10:0] got, exp_w;
    wr_en = wr; wr_sop = sop; wr_eop = eop; wr_data = d; rd_enb = rd;
    lev = mq.size();
    hd  = (lev != 0) ? mq[0] : 10'h0;
    avc = (lev >= m_mark) || (m_eops != 0);
    fr  = avc || (cfg_pkt_mode && m_xfer && lev != 0);
    pp  = rd && (lev != 0) && (avc || m_xfer);
    ps  = wr && (lev < DEPTH);
    @(posedge clk);
    e_av2 = e_av1; e_av1 = fr;
    e_w2 = e_w1;   e_w1 = pp ? {1'b1, hd} : 11'h0;
    if (lev == 0 && !m_xfer) m_mark = int'(cfg_low_mark);
    if (pp) m_xfer = !hd[8];
    else if (lev == 0) m_xfer = 0;
    if (pp) begin void'(mq.pop_front()); if (hd[8]) m_eops--; end
    if (ps) begin mq.push_back({sop, eop, d}); if (eop) m_eops++; end
    @(negedge clk);
    got   = {rx_valid, rx_sop, rx_eop, rx_data};
    exp_w = cfg_two_cycle ? e_w2 : e_w1;
    check(rx_avail == (cfg_two_cycle ? e_av2 : e_av1), tag, "rx_avail",
          rx_avail, cfg_two_cycle ? e_av2 : e_av1);
    check(got == exp_w, tag, "egress word", got, exp_w);
    check(wr_full == (mq.size() == DEPTH), tag, "wr_full", wr_full,
          mq.size() == DEPTH);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    // R11 reset state
    do_reset(1'b0, 1'b0, 4);
    check(rx_avail == 0 && rx_valid == 0 && wr_full == 0 &&
          rx_sop == 0 && rx_eop == 0 && rx_data == '0, "R11", "reset outputs",
          {rx_avail, rx_valid, wr_full, rx_sop, rx_eop, rx_data}, 0);
    step(0, 0, 0, 8'h00, 0, "R11");

    // R1 table walk, cell mode, mark 4
    for (int i = 0; i < NV; i++)
      step(VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][7:0], VEC[i][8], "R1");

    // R2 below mark, no end marker
    do_reset(1'b0, 1'b0, 4);
    step(1, 1, 0, 8'h50, 0, "R2");
    step(1, 0, 0, 8'h51, 0, "R2");
    step(1, 0, 0, 8'h52, 0, "R2");
    step(0, 0, 0, 8'h00, 0, "R2");
    check(rx_avail == 0, "R2", "flag below mark", rx_avail, 0);
    // R5 filler reads leave the FIFO untouched
    step(0, 0, 0, 8'h00, 1, "R5");
    check(rx_valid == 0 && rx_data == '0, "R5", "filler word",
          {rx_valid, rx_data}, 0);
    step(0, 0, 0, 8'h00, 1, "R5");
    step(1, 0, 0, 8'h53, 0, "R5");
    step(0, 0, 0, 8'h00, 1, "R3");
    check(rx_valid == 1 && rx_data == 8'h50 && rx_sop == 1, "R3",
          "first word one clock after enable", {rx_valid, rx_sop, rx_data},
          {1'b1, 1'b1, 8'h50});
    // R2 last word of cell leaves
    step(0, 0, 0, 8'h00, 1, "R2");
    step(0, 0, 0, 8'h00, 1, "R2");
    step(0, 0, 0, 8'h00, 1, "R2");
    step(0, 0, 0, 8'h00, 0, "R2");
    check(rx_avail == 0, "R2", "flag after drain", rx_avail, 0);

    // R6 transfer continues below mark, filler when empty
    do_reset(1'b0, 1'b0, 4);
    step(1, 1, 0, 8'h60, 0, "R6");
    for (int i = 1; i < 4; i++) step(1, 0, 0, 8'(8'h60 + i), 0, "R6");
    for (int i = 0; i < 5; i++) begin
      step(0, 0, 0, 8'h00, 1, "R6");
      if (i == 3)
        check(rx_valid == 1 && rx_data == 8'h63, "R6", "read below mark",
              {rx_valid, rx_data}, {1'b1, 8'h63});
      if (i == 4)
        check(rx_valid == 0, "R6", "empty read is filler", rx_valid, 0);
    end

    // R7 packet mode hold
    do_reset(1'b1, 1'b0, 3);
    step(1, 1, 0, 8'h70, 0, "R7");
    for (int i = 1; i < 5; i++) step(1, 0, 0, 8'(8'h70 + i), 0, "R7");
    for (int i = 0; i < 6; i++) begin
      step(0, 0, 0, 8'h00, 1, "R7");
      if (i == 3) check(rx_avail == 1, "R7", "flag held below mark", rx_avail, 1);
      if (i == 5) check(rx_avail == 0, "R7", "flag after drain", rx_avail, 0);
    end

    // R4 two-clock latency
    do_reset(1'b0, 1'b1, 2);
    step(1, 1, 0, 8'h80, 0, "R4");
    step(1, 0, 0, 8'h81, 0, "R4");
    check(rx_avail == 0, "R4", "flag not yet visible", rx_avail, 0);
    step(0, 0, 0, 8'h00, 1, "R4");
    check(rx_valid == 0, "R4", "data not after one clock", rx_valid, 0);
    step(0, 0, 0, 8'h00, 1, "R4");
    check(rx_valid == 1 && rx_data == 8'h80, "R4", "data after two clocks",
          {rx_valid, rx_data}, {1'b1, 8'h80});
    step(0, 0, 0, 8'h00, 0, "R4");
    step(0, 0, 0, 8'h00, 0, "R4");

    // R8 simultaneous end-marker write and read
    do_reset(1'b0, 1'b0, 8);
    step(1, 1, 0, 8'h90, 0, "R8");
    step(1, 0, 1, 8'h91, 0, "R8");
    step(0, 0, 0, 8'h00, 1, "R8");
    step(1, 1, 1, 8'h92, 1, "R8");
    step(0, 0, 0, 8'h00, 0, "R8");
    check(rx_avail == 1, "R8", "marker count kept", rx_avail, 1);
    step(0, 0, 0, 8'h00, 1, "R8");
    check(rx_eop == 1 && rx_data == 8'h92, "R8", "second marker word",
          {rx_eop, rx_data}, {1'b1, 8'h92});
    step(0, 0, 0, 8'h00, 0, "R8");
    step(0, 0, 0, 8'h00, 0, "R8");
    check(rx_avail == 0, "R8", "marker count zero", rx_avail, 0);

    // R9 mark change while not idle is ignored
    do_reset(1'b0, 1'b0, 4);
    step(1, 1, 0, 8'hA0, 0, "R9");
    step(1, 0, 0, 8'hA1, 0, "R9");
    cfg_low_mark = CW'(1);
    step(0, 0, 0, 8'h00, 0, "R9");
    step(0, 0, 0, 8'h00, 0, "R9");
    check(rx_avail == 0, "R9", "mark kept during fill", rx_avail, 0);

    // R10 full FIFO drops writes
    do_reset(1'b0, 1'b0, 16);
    for (int i = 0; i < DEPTH; i++) step(1, i == 0, 0, 8'(8'hB0 + i), 0, "R10");
    check(wr_full == 1, "R10", "full at depth", wr_full, 1);
    step(1, 0, 0, 8'hEE, 0, "R10");
    for (int i = 0; i < DEPTH + 1; i++) begin
      step(0, 0, 0, 8'h00, 1, "R10");
      if (i == DEPTH - 1)
        check(rx_data == 8'hBF && rx_valid == 1, "R10", "last stored word",
              {rx_valid, rx_data}, {1'b1, 8'hBF});
      if (i == DEPTH)
        check(rx_valid == 0, "R10", "dropped word absent", rx_valid, 0);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule